// File: doc/BRIEF.md
# Table-Based Spreading Code NCO

This block steps through a stored ranging code at a chip rate set by a frequency word. A 26-bit phase accumulator adds the frequency word on every sample clock. Each carry out of the accumulator moves a half-chip index forward by one position. The index addresses a code table that holds one sample per half chip, so the code is looked up rather than generated by shift registers at run time. The table contents are fixed when the design is built: each selectable table holds a 1023-chip Gold sequence.

The index also addresses the early sample (one half chip ahead) and the late sample (one half chip behind). From these the block forms an early-minus-late value. A one-cycle dump strobe marks each pass through the end of the code period, which is where an integration period ends. A latch strobe freezes the coarse phase (the index) and the fine phase (the top accumulator bits) together, so a tracking loop can read both.

The code outputs follow the sample clock and have no valid/ready handshake. One new code sample exists on every clock, and the block cannot stall the sample stream, so there is no back-pressure to apply. The control pins and the measurement pins are plain levels.

Top module: `spread_code_nco`

## Requirements
- R1: On every clock edge out of reset, the 26-bit accumulator takes the value (accumulator + `fcw_i`) mod 2^26. Its top 10 bits (bits 25..16) are visible through `meas_frac_o` after a latch.
- R2: A carry out of the accumulator advances the half-chip index by one, and a clock with no carry leaves the index unchanged. The index runs from 0 to 2045 and goes from 2045 to 0.
- R3: `prompt_o` equals the chip at position floor(index/2) of the selected Gold sequence, with 1 meaning chip value 1. G1 has feedback taps 3 and 10. G2 has feedback taps 2, 3, 6, 8, 9 and 10. Both registers start at all ones, and the output is G1 stage 10 XOR two G2 stages. The G2 stages are (2,6) for select 0 and (3,7) for select 1.
- R4: `dump_o` is high for exactly one clock: the clock in which the index has just gone from 2045 to 0. It is low at all other times.
- R5: The early sample is taken at index+1 and the late sample at index−1, both modulo 2046. At index 2045 the early sample is at 0, and at index 0 the late sample is at 2045.
- R6: `eml_o` is a signed 3-bit value equal to v(early) − v(late), where v(0)=+1 and v(1)=−1. It only ever takes the values −2, 0 and +2.
- R7: In a clock where `meas_latch_i` is high, `meas_idx_o` and `meas_frac_o` capture the index and accumulator bits 25..16 as they stood before that edge, both from the same cycle. Otherwise they hold their values.
- R8: After reset, the accumulator, the index, `dump_o`, `meas_idx_o` and `meas_frac_o` are all zero, and `prompt_o` shows table entry 0.
- R9: A select value of 2 or more (with the default two tables) reads table 0.
- R10: With `fcw_i` = 0, the accumulator and the index stay where they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fcw_i | input | 26 | Frequency word added on every clock |
| prn_sel_i | input | 2 | Code table select |
| meas_latch_i | input | 1 | Capture strobe for the phase measurements |
| prompt_o | output | 1 | Prompt code sample |
| eml_o | output | 3 | Signed early-minus-late value |
| dump_o | output | 1 | One-clock end-of-code-period strobe |
| meas_idx_o | output | 11 | Latched half-chip index |
| meas_frac_o | output | 10 | Latched top accumulator bits |

## Verification
The hardest case to reach from the ports is the wrap of the index at the end of the code period. It requires 2046 accumulator carries, and it is also the only place where the early and late neighbours wrap across the table ends and where the dump strobe fires. The stimulus uses frequency words close to 2^26, which give a carry on nearly every clock, so several wraps occur within a few thousand cycles. A measurement latch is strobed often enough that some captures fall next to a wrap. A zero frequency word and an out-of-range select are then applied, and a behavioural model in the bench is compared against the design on every clock.

// File: rtl/sc_nco_pkg.sv
package sc_nco_pkg;

  localparam int CA_LEN = 1023;

  function automatic int g2_tap_a(input int sel);
    case (sel)
      0: return 2;
      1: return 3;
      2: return 4;
      3: return 5;
      4: return 1;
      5: return 2;
      6: return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int g2_tap_b(input int sel);
    case (sel)
      0: return 6;
      1: return 7;
      2: return 8;
      3: return 9;
      4: return 9;
      5: return 10;
      6: return 8;
      default: return 9;
    endcase
  endfunction

  // Builds one code period; bit k holds chip k.
  function automatic logic [CA_LEN-1:0] gold_chips(input int sel);
    logic [10:1]       g1;
    logic [10:1]       g2;
    logic [CA_LEN-1:0] seq;
    logic              f1;
    logic              f2;
    int                ta;
    int                tb;
    g1  = '1;
    g2  = '1;
    seq = '0;
    ta  = g2_tap_a(sel);
    tb  = g2_tap_b(sel);
    for (int k = 0; k < CA_LEN; k++) begin
      seq[k] = g1[10] ^ g2[ta] ^ g2[tb];
      f1 = g1[3] ^ g1[10];
      f2 = g2[2] ^ g2[3] ^ g2[6] ^ g2[8] ^ g2[9] ^ g2[10];
      g1 = {g1[9:1], f1};
      g2 = {g2[9:1], f2};
    end
    return seq;
  endfunction

endpackage

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
  parameter int ACC_W      = 26,
  parameter int HALF_CHIPS = 2046,
  parameter int IDX_W      = $clog2(HALF_CHIPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] fcw,
  output logic [ACC_W-1:0] acc_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             dump_q
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(HALF_CHIPS - 1);

  logic [ACC_W:0] sum;
  logic           carry;
  logic           at_last;

  assign sum     = {1'b0, acc_q} + {1'b0, fcw};
  assign carry   = sum[ACC_W];
  assign at_last = (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      idx_q  <= '0;
      dump_q <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      dump_q <= carry & at_last;
      if (carry) begin
        idx_q <= at_last ? '0 : idx_q + 1'b1;
      end
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);                                                    // R2
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !carry |=> $stable(idx_q));                                        // R2
  AST_DUMP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dump_q |-> (idx_q == '0));                                         // R4
  AST_DUMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dump_q |=> !dump_q);                                               // R4
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (fcw == '0) |=> $stable(acc_q));                                   // R10

endmodule

// File: rtl/sc_code_rom.sv
module sc_code_rom
  import sc_nco_pkg::*;
#(
  parameter int NUM_PRN       = 2,
  parameter int SEL_W         = 2,
  parameter int HALF_PER_CHIP = 2,
  parameter int HALF_CHIPS    = CA_LEN * HALF_PER_CHIP,
  parameter int IDX_W         = $clog2(HALF_CHIPS)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [IDX_W-1:0] idx_p,
  input  logic [IDX_W-1:0] idx_e,
  input  logic [IDX_W-1:0] idx_l,
  output logic             bit_p,
  output logic             bit_e,
  output logic             bit_l
);

  localparam int CHIP_W = $clog2(CA_LEN);

  function automatic logic [CHIP_W-1:0] chip_of(input logic [IDX_W-1:0] idx);
    int q;
    q = int'(idx) / HALF_PER_CHIP;
    return CHIP_W'(q);
  endfunction

  logic [NUM_PRN-1:0] tbl_p;
  logic [NUM_PRN-1:0] tbl_e;
  logic [NUM_PRN-1:0] tbl_l;

  for (genvar g = 0; g < NUM_PRN; g++) begin : g_tab
    localparam logic [CA_LEN-1:0] CODE = gold_chips(g);
    assign tbl_p[g] = CODE[chip_of(idx_p)];
    assign tbl_e[g] = CODE[chip_of(idx_e)];
    assign tbl_l[g] = CODE[chip_of(idx_l)];
  end

  // Selects beyond the stored tables fall back to table 0.
  always_comb begin
    bit_p = tbl_p[0];
    bit_e = tbl_e[0];
    bit_l = tbl_l[0];
    for (int g = 1; g < NUM_PRN; g++) begin
      if (int'(sel) == g) begin
        bit_p = tbl_p[g];
        bit_e = tbl_e[g];
        bit_l = tbl_l[g];
      end
    end
  end

endmodule

// File: rtl/sc_meas_latch.sv
module sc_meas_latch #(
  parameter int ACC_W  = 26,
  parameter int FRAC_W = 10,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ACC_W-1:0]  acc,
  output logic [IDX_W-1:0]  m_idx,
  output logic [FRAC_W-1:0] m_frac
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx  <= '0;
      m_frac <= '0;
    end else if (latch) begin
      m_idx  <= idx;
      m_frac <= acc[ACC_W-1 -: FRAC_W];
    end
  end

  AST_MEAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> ($stable(m_idx) && $stable(m_frac)));                  // R7
  AST_MEAS_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (m_idx == $past(idx)));                                  // R7

endmodule

// File: rtl/spread_code_nco.sv
module spread_code_nco
  import sc_nco_pkg::*;
#(
  parameter int ACC_W         = 26,
  parameter int FRAC_W        = 10,
  parameter int HALF_PER_CHIP = 2,
  parameter int NUM_PRN       = 2,
  parameter int SEL_W         = 2,
  localparam int HALF_CHIPS   = CA_LEN * HALF_PER_CHIP,
  localparam int IDX_W        = $clog2(HALF_CHIPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ACC_W-1:0]         fcw_i,
  input  logic [SEL_W-1:0]         prn_sel_i,
  input  logic                     meas_latch_i,
  output logic                     prompt_o,
  output logic signed [2:0]        eml_o,
  output logic                     dump_o,
  output logic [IDX_W-1:0]         meas_idx_o,
  output logic [FRAC_W-1:0]        meas_frac_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(HALF_CHIPS - 1);

  logic [ACC_W-1:0] acc;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_early;
  logic [IDX_W-1:0] idx_late;
  logic             b_early;
  logic             b_late;

  sc_phase_acc #(
    .ACC_W(ACC_W), .HALF_CHIPS(HALF_CHIPS), .IDX_W(IDX_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .fcw(fcw_i),
    .acc_q(acc), .idx_q(idx), .dump_q(dump_o)
  );

  assign idx_early = (idx == LAST) ? '0 : idx + 1'b1;
  assign idx_late  = (idx == '0) ? LAST : idx - 1'b1;

  sc_code_rom #(
    .NUM_PRN(NUM_PRN), .SEL_W(SEL_W), .HALF_PER_CHIP(HALF_PER_CHIP),
    .HALF_CHIPS(HALF_CHIPS), .IDX_W(IDX_W)
  ) u_rom (
    .sel(prn_sel_i), .idx_p(idx), .idx_e(idx_early), .idx_l(idx_late),
    .bit_p(prompt_o), .bit_e(b_early), .bit_l(b_late)
  );

  // v(0)=+1, v(1)=-1
  always_comb begin
    if (b_early == b_late) eml_o = 3'sd0;
    else if (b_early)      eml_o = -3'sd2;
    else                   eml_o = 3'sd2;
  end

  sc_meas_latch #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)
  ) u_meas (
    .clk(clk), .rst_n(rst_n), .latch(meas_latch_i), .idx(idx), .acc(acc),
    .m_idx(meas_idx_o), .m_frac(meas_frac_o)
  );

  AST_EML_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (eml_o == 3'sd0) || (eml_o == 3'sd2) || (eml_o == -3'sd2));        // R6
  AST_DUMP_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == LAST) ##1 (idx == '0) |-> dump_o);                        // R4

endmodule

// File: tb/spread_code_nco_tb_top.sv
module spread_code_nco_tb_top;

  localparam int M      = 1 << 26;
  localparam int HALF   = 2046;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] fcw = '0;
  logic [1:0]  sel = '0;
  logic        latch = 1'b0;
  logic        prompt;
  logic signed [2:0] eml;
  logic        dump;
  logic [10:0] m_idx;
  logic [9:0]  m_frac;

  always #5 clk = ~clk;

  spread_code_nco dut_i (
    .clk(clk), .rst_n(rst_n), .fcw_i(fcw), .prn_sel_i(sel),
    .meas_latch_i(latch), .prompt_o(prompt), .eml_o(eml), .dump_o(dump),
    .meas_idx_o(m_idx), .meas_frac_o(m_frac)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  bit  tab[2][HALF];

  // model state
  longint r_acc;
  int     r_idx;
  int     r_dump;
  int     r_midx;
  int     r_mfrac;

  task automatic build_tables();
    int ta[2] = '{2, 3};
    int tb[2] = '{6, 7};
    for (int s = 0; s < 2; s++) begin
      int g1[11];
      int g2[11];
      for (int i = 1; i <= 10; i++) begin g1[i] = 1; g2[i] = 1; end
      for (int k = 0; k < 1023; k++) begin
        int c;
        int f1;
        int f2;
        c  = g1[10] ^ g2[ta[s]] ^ g2[tb[s]];
        tab[s][2*k]   = c[0];
        tab[s][2*k+1] = c[0];
        f1 = g1[3] ^ g1[10];
        f2 = g2[2] ^ g2[3] ^ g2[6] ^ g2[8] ^ g2[9] ^ g2[10];
        for (int i = 10; i >= 2; i--) begin g1[i] = g1[i-1]; g2[i] = g2[i-1]; end
        g1[1] = f1;
        g2[1] = f2;
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int val(input bit b);
    return b ? -1 : 1;
  endfunction

  task automatic compare(input string ptag, input string mtag);
    int s;
    int e_i;
    int l_i;
    int exp_eml;
    s   = (int'(sel) < 2) ? int'(sel) : 0;
    e_i = (r_idx + 1) % HALF;
    l_i = (r_idx + HALF - 1) % HALF;
    exp_eml = val(tab[s][e_i]) - val(tab[s][l_i]);
    check(prompt == tab[s][r_idx], ptag, int'(prompt), int'(tab[s][r_idx]));
    check(int'(eml) == exp_eml, "R5/R6 eml", int'(eml), exp_eml);
    check(int'(dump) == r_dump, "R4 dump", int'(dump), r_dump);
    check(int'(m_idx) == r_midx, {mtag, " R2 idx"}, int'(m_idx), r_midx);
    check(int'(m_frac) == r_mfrac, {mtag, " R1 frac"}, int'(m_frac), r_mfrac);
  endtask

  task automatic step(input int f, input bit lat, input int s,
                      input string ptag, input string mtag);
    longint sum;
    fcw   = 26'(f);
    latch = lat;
    sel   = 2'(s);
    @(posedge clk);
    if (lat) begin
      r_midx  = r_idx;
      r_mfrac = int'(r_acc >> 16);
    end
    sum    = r_acc + longint'(f);
    r_dump = 0;
    if (sum >= M) begin
      if (r_idx == HALF - 1) r_dump = 1;
      r_idx = (r_idx + 1) % HALF;
    end
    r_acc = sum % M;
    @(negedge clk);
    compare(ptag, mtag);
  endtask

  initial begin
    build_tables();
    r_acc = 0; r_idx = 0; r_dump = 0; r_midx = 0; r_mfrac = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(dump == 1'b0, "R8 dump", int'(dump), 0);
    check(m_idx == '0, "R8 meas_idx", int'(m_idx), 0);
    check(m_frac == '0, "R8 meas_frac", int'(m_frac), 0);
    check(prompt == tab[0][0], "R8 prompt", int'(prompt), int'(tab[0][0]));
    // near-maximum rate, table 0, wraps twice
    for (int i = 0; i < 4500; i++)
      step(M - 1, (i % 37) == 0, 0, "R3 prompt", "R7");
    // odd rate, table 1
    for (int i = 0; i < 3000; i++)
      step(32'h02AA_AAAB, (i % 13) == 5, 1, "R3 prompt", "R7");
    // zero word freezes phase
    for (int i = 0; i < 200; i++)
      step(0, (i % 5) == 0, 1, "R3 prompt", "R10");
    // out-of-range select reads table 0
    for (int i = 0; i < 2500; i++)
      step(M - 3, (i % 29) == 3, 3, "R9 prompt", "R7");
    // latch every clock
    for (int i = 0; i < 500; i++)
      step((M / 2) + 12345, 1'b1, 2, "R9 prompt", "R7");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule